// File: doc/BRIEF.md
# Integer Requantization Output Stage

This block sits behind the multiply-accumulate array of a convolution or matrix-multiply engine and turns wide accumulator sums into narrow activation words. Each output channel lane receives a signed accumulator sum together with its own bias and scale. The lane adds the bias, multiplies the biased sum by the scale at full precision, and shifts the product right by a programmable amount. The shift rounds half away from zero. The lane can then apply a ReLU, and it saturates the result to the signed activation width.

Several lanes are handled in each beat. Beats enter and leave on a valid/ready stream. The shift amount and the ReLU enable are sampled together with each accepted beat, so a layer change can follow its last beat at once. The pipeline has three register stages and the whole pipe stalls when the output is held off.

Top module: `requant_stage`

## Requirements
- R1: During reset (`rst_n` low at a clock edge) the pipe empties. Right after reset, `out_valid` is 0 and `in_ready` is 1, and no output beat is presented for which no input beat was accepted.
- R2: For each lane the result is clip(relu(round((acc + bias) * scale / 2^shamt))). The bias is added before the scale is applied, and each lane uses only its own bias and scale.
- R3: The sum is held at accumulator width plus one bit and the product at sum width plus coefficient width. An accumulator of -2^63 with bias -1 and scale -32768 does not wrap before the shift and clip.
- R4: For shift amounts of 1 or more, rounding is half away from zero. With shamt=1: 3→2, -3→-2, 5→3, -5→-3, 1→1, -1→-1. With shamt=2: 6→2, -6→-2, 5→1.
- R5: A shift amount of 0 passes the product unchanged into the ReLU and clip.
- R6: When `cfg_relu` is 1, negative results become 0 and positive results are unaffected. When it is 0, negative results pass through.
- R7: Results above 32767 become 32767 and results below -32768 become -32768. There is no wrap.
- R8: Lane i occupies bits [i*64 +: 64] of `in_acc`, bits [i*16 +: 16] of `in_bias` and `in_scale`, and bits [i*16 +: 16] of `out_data`. The lanes are computed independently.
- R9: A beat accepted at clock edge k is presented on `out_data` with `out_valid` high after edge k+2, provided the pipe advances on edges k+1 and k+2. No more than three beats are in flight.
- R10: While `out_valid` is 1 and `out_ready` is 0, `out_data` holds steady and `in_ready` is 0. Every accepted beat is output exactly once and in order.
- R11: `cfg_shamt` (0 to 127) and `cfg_relu` are captured with each accepted beat. Changing them on every beat gives each beat its own setting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Input beat present |
| in_ready | output | 1 | Stage accepts a beat at this edge |
| in_acc | input | LANES*ACC_W | Signed accumulator sums, one per lane |
| in_bias | input | LANES*COEF_W | Signed bias, one per lane |
| in_scale | input | LANES*COEF_W | Signed scale, one per lane |
| cfg_shamt | input | 7 | Right shift amount for this beat |
| cfg_relu | input | 1 | ReLU enable for this beat |
| out_valid | output | 1 | Output beat present |
| out_ready | input | 1 | Consumer takes the output beat |
| out_data | output | LANES*OUT_W | Saturated signed activations, one per lane |

## Verification
The assertions assume that the consumer may drop `out_ready` in any cycle and that the producer keeps its inputs steady only in cycles where it sees the handshake. The bench therefore drives `out_ready` low at random during a stall phase. It changes the input fields only after each acceptance edge, so the stall and hold properties are exercised on real backpressure. The latency property assumes that the pipe advances on the two edges after acceptance. The bench checks exact latency only in phases where `out_ready` stays high.

// File: rtl/requant_pkg.sv
// Shared constants and types for the requantization stage.
// Assumes the shift amount field is wide enough for any product width used.
package requant_pkg;
    localparam int SHAMT_W    = 7;
    localparam int PIPE_DEPTH = 3;

    // Per-beat layer setting carried down the pipe beside the data
    typedef struct packed {
        logic [SHAMT_W-1:0] shamt;
        logic               relu;
    } rq_cfg_t;
endpackage

// File: rtl/rq_pipe_ctrl.sv
// Valid and per-beat configuration pipeline for the requantization stage.
// Every stage advances together. The whole pipe holds when the last stage
// is full and the consumer is not ready. Assumes a fixed depth of three.
module rq_pipe_ctrl
    import requant_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  logic    in_valid,
    input  logic    out_ready,
    input  rq_cfg_t cfg_i,
    output logic    adv_o,
    output logic    in_ready_o,
    output logic    out_valid_o,
    output rq_cfg_t cfg_s2_o
);
    logic    v1_q, v2_q, v3_q;
    rq_cfg_t cfg1_q, cfg2_q;

    assign adv_o       = !v3_q || out_ready;
    assign in_ready_o  = adv_o;
    assign out_valid_o = v3_q;
    assign cfg_s2_o    = cfg2_q;

    // Move valid flags one stage per advancing edge
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            v1_q <= 1'b0;
            v2_q <= 1'b0;
            v3_q <= 1'b0;
        end else if (adv_o) begin
            v1_q <= in_valid;
            v2_q <= v1_q;
            v3_q <= v2_q;
        end
    end

    // Keep the shift and ReLU setting aligned with its beat
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg1_q <= '0;
            cfg2_q <= '0;
        end else if (adv_o) begin
            cfg1_q <= cfg_i;
            cfg2_q <= cfg1_q;
        end
    end
endmodule

// File: rtl/rq_prescale.sv
// Bias add followed by scale multiply, at full precision over two stages.
// Stage one widens the sum by one bit. Stage two holds the complete signed
// product, so nothing overflows before the shift and clip.
module rq_prescale #(
    parameter int ACC_W  = 64,
    parameter int COEF_W = 16,
    localparam int SUM_W  = ACC_W + 1,
    localparam int PROD_W = SUM_W + COEF_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en_i,
    input  logic [ACC_W-1:0]  acc_i,
    input  logic [COEF_W-1:0] bias_i,
    input  logic [COEF_W-1:0] scale_i,
    output logic [PROD_W-1:0] prod_o
);
    logic signed [SUM_W-1:0]  sum_d, sum_q;
    logic signed [COEF_W-1:0] scale_q;
    logic signed [PROD_W-1:0] prod_q;

    assign sum_d = $signed({acc_i[ACC_W-1], acc_i})
                 + $signed({{(SUM_W-COEF_W){bias_i[COEF_W-1]}}, bias_i});

    // Register the biased sum and the scale that goes with it
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sum_q   <= '0;
            scale_q <= '0;
        end else if (en_i) begin
            sum_q   <= sum_d;
            scale_q <= $signed(scale_i);
        end
    end

    // Register the full-width signed product
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prod_q <= '0;
        end else if (en_i) begin
            prod_q <= PROD_W'(sum_q) * PROD_W'(scale_q);
        end
    end

    assign prod_o = prod_q;
endmodule

// File: rtl/rq_shift_round.sv
// Combinational arithmetic right shift with rounding half away from zero.
// The shift works on the magnitude and the sign is restored afterwards.
// A shift of zero passes the value through. The output is one bit wider
// than the input so that the most negative input survives a zero shift.
module rq_shift_round #(
    parameter int IN_W    = 81,
    parameter int SHAMT_W = 7,
    localparam int RES_W  = IN_W + 1
) (
    input  logic [IN_W-1:0]    val_i,
    input  logic [SHAMT_W-1:0] shamt_i,
    output logic [RES_W-1:0]   res_o
);
    localparam int MW = IN_W + 2;

    logic          neg;
    logic [MW-1:0] ext, mag, half, biased, shifted;

    // Round the magnitude, then restore the sign
    always_comb begin
        neg     = val_i[IN_W-1];
        ext     = {{2{val_i[IN_W-1]}}, val_i};
        mag     = neg ? (~ext + MW'(1)) : ext;
        half    = (shamt_i == '0) ? '0 : (MW'(1) << (shamt_i - SHAMT_W'(1)));
        biased  = mag + half;
        shifted = biased >> shamt_i;
        res_o   = neg ? (~shifted[RES_W-1:0] + RES_W'(1)) : shifted[RES_W-1:0];
    end
endmodule

// File: rtl/rq_saturate.sv
// Optional ReLU followed by signed saturation to the activation width.
// The value fits when all bits from the output sign bit upwards are equal.
// Otherwise it clamps to the nearer extreme.
module rq_saturate #(
    parameter int IN_W  = 82,
    parameter int OUT_W = 16
) (
    input  logic [IN_W-1:0]  val_i,
    input  logic             relu_i,
    output logic [OUT_W-1:0] res_o
);
    logic neg, fits;

    // Pick zero, pass-through or a clamp value
    always_comb begin
        neg  = val_i[IN_W-1];
        fits = (val_i[IN_W-1:OUT_W-1] == '0) || (val_i[IN_W-1:OUT_W-1] == '1);
        if (relu_i && neg)
            res_o = '0;
        else if (fits)
            res_o = val_i[OUT_W-1:0];
        else if (neg)
            res_o = {1'b1, {(OUT_W-1){1'b0}}};
        else
            res_o = {1'b0, {(OUT_W-1){1'b1}}};
    end
endmodule

// File: rtl/rq_lane.sv
// One output-channel lane: prescale, rounded shift, ReLU/clip and the
// output register. Assumes the shift and ReLU inputs are already aligned
// with the product held in the prescale stage.
module rq_lane #(
    parameter int ACC_W   = 64,
    parameter int COEF_W  = 16,
    parameter int OUT_W   = 16,
    parameter int SHAMT_W = 7
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               en_i,
    input  logic [ACC_W-1:0]   acc_i,
    input  logic [COEF_W-1:0]  bias_i,
    input  logic [COEF_W-1:0]  scale_i,
    input  logic [SHAMT_W-1:0] shamt_i,
    input  logic               relu_i,
    output logic [OUT_W-1:0]   res_o
);
    localparam int PROD_W = ACC_W + 1 + COEF_W;
    localparam int RND_W  = PROD_W + 1;

    logic [PROD_W-1:0] prod;
    logic [RND_W-1:0]  rounded;
    logic [OUT_W-1:0]  clipped;
    logic [OUT_W-1:0]  res_q;

    rq_prescale #(
        .ACC_W (ACC_W),
        .COEF_W(COEF_W)
    ) u_prescale (
        .clk    (clk),
        .rst_n  (rst_n),
        .en_i   (en_i),
        .acc_i  (acc_i),
        .bias_i (bias_i),
        .scale_i(scale_i),
        .prod_o (prod)
    );

    rq_shift_round #(
        .IN_W   (PROD_W),
        .SHAMT_W(SHAMT_W)
    ) u_shift (
        .val_i  (prod),
        .shamt_i(shamt_i),
        .res_o  (rounded)
    );

    rq_saturate #(
        .IN_W (RND_W),
        .OUT_W(OUT_W)
    ) u_sat (
        .val_i (rounded),
        .relu_i(relu_i),
        .res_o (clipped)
    );

    // Hold the finished activation for the stream output
    always_ff @(posedge clk) begin
        if (!rst_n)
            res_q <= '0;
        else if (en_i)
            res_q <= clipped;
    end

    assign res_o = res_q;
endmodule

// File: rtl/requant_stage.sv
// Requantization output stage: LANES parallel channel lanes behind one
// valid/ready stream. A beat accepted at edge k appears after edge k+2
// when the pipe is not stalled. Assumes the producer holds its inputs
// until in_ready is seen with in_valid.
module requant_stage
    import requant_pkg::*;
#(
    parameter int LANES  = 2,
    parameter int ACC_W  = 64,
    parameter int COEF_W = 16,
    parameter int OUT_W  = 16
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    in_valid,
    output logic                    in_ready,
    input  logic [LANES*ACC_W-1:0]  in_acc,
    input  logic [LANES*COEF_W-1:0] in_bias,
    input  logic [LANES*COEF_W-1:0] in_scale,
    input  logic [SHAMT_W-1:0]      cfg_shamt,
    input  logic                    cfg_relu,
    output logic                    out_valid,
    input  logic                    out_ready,
    output logic [LANES*OUT_W-1:0]  out_data
);
    logic    adv;
    rq_cfg_t cfg_in, cfg_s2;

    assign cfg_in = '{shamt: cfg_shamt, relu: cfg_relu};

    rq_pipe_ctrl u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .in_valid   (in_valid),
        .out_ready  (out_ready),
        .cfg_i      (cfg_in),
        .adv_o      (adv),
        .in_ready_o (in_ready),
        .out_valid_o(out_valid),
        .cfg_s2_o   (cfg_s2)
    );

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        rq_lane #(
            .ACC_W  (ACC_W),
            .COEF_W (COEF_W),
            .OUT_W  (OUT_W),
            .SHAMT_W(SHAMT_W)
        ) u_lane (
            .clk    (clk),
            .rst_n  (rst_n),
            .en_i   (adv),
            .acc_i  (in_acc[g*ACC_W +: ACC_W]),
            .bias_i (in_bias[g*COEF_W +: COEF_W]),
            .scale_i(in_scale[g*COEF_W +: COEF_W]),
            .shamt_i(cfg_s2.shamt),
            .relu_i (cfg_s2.relu),
            .res_o  (out_data[g*OUT_W +: OUT_W])
        );
    end
endmodule

// File: rtl/requant_stage_chk.sv
// Protocol checker for the requantization stage, bound to every instance.
// It tracks the beats in flight from the handshakes at the ports.
module requant_stage_chk #(
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic              in_ready,
    input logic              out_valid,
    input logic              out_ready,
    input logic [DATA_W-1:0] out_data
);
    localparam int DEPTH = requant_pkg::PIPE_DEPTH;

    logic [3:0] occ_q;

    // Count accepted beats minus delivered beats
    always_ff @(posedge clk) begin
        if (!rst_n)
            occ_q <= '0;
        else
            occ_q <= occ_q + 4'(in_valid && in_ready) - 4'(out_valid && out_ready);
    end

    a_r1_no_spurious_valid: assert property (@(posedge clk) disable iff (!rst_n)
        (occ_q == '0) |-> !out_valid);

    a_r9_depth_bound: assert property (@(posedge clk) disable iff (!rst_n)
        occ_q <= 4'(DEPTH));

    a_r9_fixed_latency: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) ##1 in_ready ##1 in_ready |=> out_valid);

    a_r10_hold_stalled: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

    a_r10_block_input: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |-> !in_ready);
endmodule

bind requant_stage requant_stage_chk #(.DATA_W(LANES*OUT_W)) u_chk (.*);

// File: tb/requant_stage_tb.sv
`timescale 1ns/1ps
module requant_stage_tb;
    localparam int LANES  = 2;
    localparam int ACC_W  = 64;
    localparam int COEF_W = 16;
    localparam int OUT_W  = 16;
    localparam int SHW    = requant_pkg::SHAMT_W;
    localparam int DW     = LANES*OUT_W;

    logic                    clk = 1'b0;
    logic                    rst_n = 1'b0;
    logic                    in_valid = 1'b0;
    logic                    in_ready;
    logic [LANES*ACC_W-1:0]  in_acc = '0;
    logic [LANES*COEF_W-1:0] in_bias = '0;
    logic [LANES*COEF_W-1:0] in_scale = '0;
    logic [SHW-1:0]          cfg_shamt = '0;
    logic                    cfg_relu = 1'b0;
    logic                    out_valid;
    logic                    out_ready = 1'b1;
    logic [DW-1:0]           out_data;

    requant_stage u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_acc(in_acc), .in_bias(in_bias), .in_scale(in_scale),
        .cfg_shamt(cfg_shamt), .cfg_relu(cfg_relu),
        .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data)
    );

    typedef struct {
        logic [DW-1:0] data;
        string         tag;
        int            cyc;
    } exp_t;

    exp_t sb[$];
    int   n_chk = 0;
    int   n_err = 0;
    int   cyc = 0;
    bit   stall_mode = 1'b0;
    bit   lat_mode = 1'b1;
    bit   done = 1'b0;

    always #10 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // Reference: clip(relu(round_half_away((acc+bias)*scale / 2^sh)))
    function automatic logic [OUT_W-1:0] model(input longint acc, input int bias,
                                               input int scale, input int sh, input bit relu);
        logic signed [127:0] s, p, mag, q, r, dv, hi, lo;
        s = acc;
        s = s + bias;
        p = s * scale;
        if (sh == 0) r = p;
        else begin
            mag = (p < 0) ? -p : p;
            dv  = 128'sd1 <<< sh;
            q   = (mag + dv / 2) / dv;
            r   = (p < 0) ? -q : q;
        end
        hi = (128'sd1 <<< (OUT_W-1)) - 1;
        lo = -(128'sd1 <<< (OUT_W-1));
        if (relu && r < 0) r = 0;
        if (r > hi) r = hi;
        if (r < lo) r = lo;
        return r[OUT_W-1:0];
    endfunction

    // Driver: present one beat, wait for acceptance, push the expectation
    task automatic send(input longint a0, input int b0, input int s0,
                        input longint a1, input int b1, input int s1,
                        input int sh, input bit relu, input string tag);
        exp_t e;
        @(negedge clk);
        in_valid = 1'b1;
        in_acc   = {a1, a0};
        in_bias  = {b1[15:0], b0[15:0]};
        in_scale = {s1[15:0], s0[15:0]};
        cfg_shamt = SHW'(sh);
        cfg_relu  = relu;
        #2;
        while (!in_ready) begin
            @(negedge clk);
            #2;
        end
        e.data = {model(a1, b1, s1, sh, relu), model(a0, b0, s0, sh, relu)};
        e.tag  = tag;
        e.cyc  = cyc;
        sb.push_back(e);
    endtask

    task automatic idle();
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic drain();
        for (int i = 0; i < 400 && sb.size() != 0; i++) @(negedge clk);
        chk(sb.size() == 0, "R10", "beats left undelivered", 64'(sb.size()), 64'd0);
    endtask

    task automatic rand_beat(input string tag);
        longint a0, a1;
        logic [15:0] t;
        int b0, b1, s0, s1, sh;
        a0 = {$urandom(), $urandom()};
        a0 = a0 >>> ($urandom() % 60);
        a1 = {$urandom(), $urandom()};
        a1 = a1 >>> ($urandom() % 60);
        t = 16'($urandom()); b0 = int'($signed(t));
        t = 16'($urandom()); b1 = int'($signed(t));
        t = 16'($urandom()); s0 = int'($signed(t));
        t = 16'($urandom()); s1 = int'($signed(t));
        sh = int'($urandom() % 80);
        send(a0, b0, s0, a1, b1, s1, sh, 1'($urandom()), tag);
    endtask

    // Monitor: set the consumer handshake, pop and compare delivered beats
    initial begin
        bit            prev_stall = 1'b0;
        logic [DW-1:0] prev_data = '0;
        exp_t          e;
        forever begin
            @(negedge clk);
            out_ready = stall_mode ? (($urandom() % 3) != 0) : 1'b1;
            #1;
            if (rst_n) begin
                if (prev_stall)
                    chk(out_valid && out_data == prev_data, "R10", "held output changed",
                        64'(out_data), 64'(prev_data));
                if (out_valid && out_ready) begin
                    if (sb.size() == 0) begin
                        chk(1'b0, "R1", "output with nothing accepted", 64'(out_data), 64'd0);
                    end else begin
                        e = sb.pop_front();
                        chk(out_data === e.data, e.tag, "lane results", 64'(out_data), 64'(e.data));
                        if (lat_mode)
                            chk(cyc - e.cyc == 3, "R9", "latency in edges",
                                64'(cyc - e.cyc), 64'd3);
                    end
                end
                prev_stall = out_valid && !out_ready;
                prev_data  = out_data;
            end
        end
    end

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    endtask

    // Watchdog: a hung run counts as a failure and still reports
    initial begin
        repeat (60000) @(posedge clk);
        if (!done) begin
            chk(1'b0, "R10", "watchdog expired", 64'd1, 64'd0);
            finish_run();
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        #3;
        // R1: empty pipe after reset
        chk(out_valid == 1'b0, "R1", "out_valid after reset", 64'(out_valid), 64'd0);
        chk(in_ready == 1'b1, "R1", "in_ready after reset", 64'(in_ready), 64'd1);

        // R2 and R5: bias before scale, zero shift passes through
        send(1000, 24, 3, -500, -12, 2, 0, 1'b0, "R2");
        idle();
        send(7, -7, 100, 20, 5, -4, 0, 1'b0, "R5");
        // R4: rounding half away from zero
        send(3, 0, 1, -3, 0, 1, 1, 1'b0, "R4");
        send(5, 0, 1, -5, 0, 1, 1, 1'b0, "R4");
        send(1, 0, 1, -1, 0, 1, 1, 1'b0, "R4");
        send(6, 0, 1, -6, 0, 1, 2, 1'b0, "R4");
        send(5, 0, 1, 5, 0, -1, 2, 1'b0, "R4");
        // R3: extreme sum and product widths
        send(longint'(64'h8000_0000_0000_0000), -1, -32768,
             longint'(64'h4000_0000_0000_0000), 0, 32767, 78, 1'b0, "R3");
        send(longint'(64'h7FFF_FFFF_FFFF_FFFF), 32767, 32767,
             longint'(64'h8000_0000_0000_0000), -32768, 32767, 79, 1'b0, "R3");
        // R7: saturation and boundaries
        send(100000, 0, 1, -100000, 0, 1, 0, 1'b0, "R7");
        send(32767, 0, 1, -32768, 0, 1, 0, 1'b0, "R7");
        send(32768, 0, 1, -32769, 0, 1, 0, 1'b0, "R7");
        // R6: ReLU on and off
        send(-100, 0, 1, 100, 0, 1, 0, 1'b1, "R6");
        send(-100000, 0, 1, 0, -1, 1, 0, 1'b1, "R6");
        send(-100, 0, 1, -9, 0, 1, 0, 1'b0, "R6");
        // R8: lanes with very different operands
        send(123456, -300, 7, -654321, 250, -9, 4, 1'b0, "R8");
        idle();
        drain();

        // R11: setting changes on every back-to-back beat
        for (int i = 0; i < 40; i++) rand_beat("R11");
        idle();
        drain();

        // R10: random backpressure, order and hold
        lat_mode = 1'b0;
        stall_mode = 1'b1;
        for (int i = 0; i < 60; i++) rand_beat("R10");
        idle();
        drain();
        stall_mode = 1'b0;
        repeat (4) @(negedge clk);
        #3;
        chk(out_valid == 1'b0, "R1", "no spurious beat when idle", 64'(out_valid), 64'd0);

        done = 1'b1;
        finish_run();
    end
endmodule